// File: doc/BRIEF.md
# Character Display Address Sequencer

This block produces the display-memory read addresses and the cell-position timing for an on-screen text overlay. The overlay has 12 character rows of up to 24 characters each. The block runs on the pixel clock and watches the horizontal and vertical sync inputs. From these, and from programmable 6-bit horizontal and vertical start offsets, it works out when the character area is being scanned. While the area is being scanned, it outputs the character-memory address, a character-active window, and the pixel column and scan line inside the current 12 x 18 cell.

Each character row fetches from its own start address in display memory, so rows need not sit next to each other in that memory. Each row also has its own horizontal and vertical pixel scaling. A frame counter advances on every vertical sync. That counter and a selectable duty cycle decide the flashing phase. The block combines the phase with the flash bit of the character being drawn to produce a show/blank gate. Glyph lookup and video mixing are done by neighbouring logic.

Top module: `char_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `char_act_o`, `ram_addr_o`, `pix_x_o` and `pix_y_o` go to 0 and `show_o` goes to 1.
- R2: Sync inputs act on their rising edge (low in the previous cycle, high now). A horizontal edge sampled at clock edge 0 starts a line. If that line lies in the vertical window, `char_act_o` is first high after edge `h_start_i*2+1`.
- R3: Each rising edge of `hsync_i` starts a line. Lines are numbered 0, 1, 2, … from the last rising edge of `vsync_i`. The window begins at line `v_start_i`. Rows 0 to 11 follow one another in order. Row r lasts 18*(h+1) lines, where h is bits [2r+1:2r] of `row_hsel_i`. While the character area is active, `pix_y_o` equals the line offset within the row divided by (h+1).
- R4: In row r each pixel lasts w+1 clocks, where w is bits [2r+1:2r] of `row_wsel_i`. `pix_x_o` runs from 0 to 11 within each character. `char_act_o` drops after 24 characters.
- R5: The first character of a line reads address `row_base_i[9r+8:9r]`. Each later character reads the previous address plus one, modulo 512.
- R6: Whenever `char_act_o` is low, `ram_addr_o` keeps the value it had on the last active cycle.
- R7: A rising edge of `hsync_i` ends the active window on the next output, even in mid-line. A rising edge of `vsync_i` also ends the active window and restarts line numbering and row order.
- R8: A 6-bit frame counter, cleared by reset, increments modulo 64 on each rising edge of `vsync_i`.
- R9: On each cycle, `show_o` is low if and only if `flash_bit_i` was 1 on the previous cycle and the frame counter was at or above the threshold. The threshold comes from `duty_i`: 1 gives 16 (shown 1/4 of the period), 3 gives 48 (shown 3/4), and 0 or 2 give 32 (shown 1/2).
- R10: A sync input held high for several cycles triggers only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| h_start_i | input | 6 | Horizontal start offset, in units of 2 clocks |
| v_start_i | input | 6 | Vertical start offset, in lines |
| row_base_i | input | 108 | Start address per row, 9 bits each, row 0 in the low bits |
| row_wsel_i | input | 24 | Pixel width code per row, 2 bits each |
| row_hsel_i | input | 24 | Pixel height code per row, 2 bits each |
| duty_i | input | 2 | Flashing duty code |
| flash_bit_i | input | 1 | Flash-enable bit of the character being drawn |
| ram_addr_o | output | 9 | Display-memory read address |
| char_act_o | output | 1 | Character area being scanned |
| pix_x_o | output | 4 | Pixel column within the cell |
| pix_y_o | output | 5 | Scan line within the cell |
| show_o | output | 1 | Flash gate, 0 blanks the character |

## Verification
The bench cuts many lines short with an early horizontal sync and checks that the window drops at once. A design that let the window run on would paint into the next line. A row base of 510 makes the address wrap through 0, where a design without the modulo would fetch out of range. The start offsets are driven to 0 and to 63, and a vertical sync lands in the middle of an active row. A design with an off-by-one start, or one that did not restart its row order, would then misplace every later row. Over many frames, all four duty codes are compared at the frame-count thresholds, and syncs are held high for several cycles so that a level-triggered design would restart its counts.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int ROWS_D   = 12;
  localparam int COLS_D   = 24;
  localparam int CELL_W_D = 12;
  localparam int CELL_H_D = 18;
  localparam int AW_D     = 9;
  localparam int POSW_D   = 6;
  localparam int SCW_D    = 2;
  localparam int FRW_D    = 6;
  localparam int H_UNIT_D = 2;
  localparam int V_UNIT_D = 1;

  localparam int SYNC_H = 0;
  localparam int SYNC_V = 1;

  typedef enum logic [1:0] {
    DUTY_ALT  = 2'd0,
    DUTY_QTR  = 2'd1,
    DUTY_HALF = 2'd2,
    DUTY_3QTR = 2'd3
  } duty_e;
endpackage

// File: rtl/cas_sync_edge.sv
module cas_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/cas_vseq.sv
module cas_vseq #(
  parameter int ROWS   = 12,
  parameter int CELL_H = 18,
  parameter int POSW   = 6,
  parameter int SCW    = 2,
  parameter int V_UNIT = 1,
  localparam int RW    = $clog2(ROWS),
  localparam int YW    = $clog2(CELL_H)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hs_rise,
  input  logic                  vs_rise,
  input  logic [POSW-1:0]       v_start,
  input  logic [ROWS*SCW-1:0]   hsel_flat,
  output logic                  v_on_o,
  output logic [RW-1:0]         row_o,
  output logic [YW-1:0]         cy_o
);
  localparam int VMAX = (2**POSW - 1) * V_UNIT;
  localparam int VW   = $clog2(VMAX + 2);

  logic [SCW-1:0] hsel_a [ROWS];
  logic [VW-1:0]  v_cnt;
  logic [VW-1:0]  vtarget;
  logic [SCW-1:0] vsub;
  logic           v_done;

  for (genvar r = 0; r < ROWS; r++) begin : g_hsel
    assign hsel_a[r] = hsel_flat[r*SCW +: SCW];
  end

  assign vtarget = VW'(v_start * V_UNIT);

  always_ff @(posedge clk) begin
    if (rst || vs_rise) begin
      v_cnt  <= '0;
      v_on_o <= 1'b0;
      v_done <= 1'b0;
      row_o  <= '0;
      cy_o   <= '0;
      vsub   <= '0;
    end else if (hs_rise) begin
      if (v_cnt != {VW{1'b1}}) v_cnt <= v_cnt + 1'b1;
      if (!v_on_o) begin
        if (!v_done && v_cnt == vtarget) begin
          v_on_o <= 1'b1;
          row_o  <= '0;
          cy_o   <= '0;
          vsub   <= '0;
        end
      end else if (vsub == hsel_a[row_o]) begin
        vsub <= '0;
        if (cy_o == YW'(CELL_H - 1)) begin
          cy_o <= '0;
          if (row_o == RW'(ROWS - 1)) begin
            v_on_o <= 1'b0;
            v_done <= 1'b1;
          end else begin
            row_o <= row_o + 1'b1;
          end
        end else begin
          cy_o <= cy_o + 1'b1;
        end
      end else begin
        vsub <= vsub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cas_hseq.sv
module cas_hseq #(
  parameter int ROWS   = 12,
  parameter int COLS   = 24,
  parameter int CELL_W = 12,
  parameter int AW     = 9,
  parameter int POSW   = 6,
  parameter int SCW    = 2,
  parameter int H_UNIT = 2,
  localparam int RW    = $clog2(ROWS),
  localparam int XW    = $clog2(CELL_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hs_rise,
  input  logic                vs_rise,
  input  logic [POSW-1:0]     h_start,
  input  logic                v_on,
  input  logic [RW-1:0]       row,
  input  logic [ROWS*AW-1:0]  base_flat,
  input  logic [ROWS*SCW-1:0] wsel_flat,
  output logic                act_o,
  output logic [AW-1:0]       addr_o,
  output logic [XW-1:0]       px_o
);
  localparam int HMAX = (2**POSW - 1) * H_UNIT;
  localparam int HW   = $clog2(HMAX + 2);
  localparam int CW   = $clog2(COLS);

  logic [AW-1:0]  base_a [ROWS];
  logic [SCW-1:0] wsel_a [ROWS];
  logic [HW-1:0]  hcnt;
  logic [HW-1:0]  htarget;
  logic           armed;
  logic [SCW-1:0] sub;
  logic [CW-1:0]  ch;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign base_a[r] = base_flat[r*AW +: AW];
    assign wsel_a[r] = wsel_flat[r*SCW +: SCW];
  end

  assign htarget = HW'(h_start * H_UNIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt   <= '0;
      armed  <= 1'b0;
      act_o  <= 1'b0;
      sub    <= '0;
      px_o   <= '0;
      ch     <= '0;
      addr_o <= '0;
    end else if (vs_rise) begin
      armed <= 1'b0;
      act_o <= 1'b0;
    end else if (hs_rise) begin
      hcnt  <= '0;
      armed <= 1'b1;
      act_o <= 1'b0;
    end else begin
      if (hcnt != {HW{1'b1}}) hcnt <= hcnt + 1'b1;
      if (armed && hcnt == htarget) begin
        armed <= 1'b0;
        if (v_on) begin
          act_o  <= 1'b1;
          sub    <= '0;
          px_o   <= '0;
          ch     <= '0;
          addr_o <= base_a[row];
        end
      end else if (act_o) begin
        if (sub == wsel_a[row]) begin
          sub <= '0;
          if (px_o == XW'(CELL_W - 1)) begin
            px_o <= '0;
            if (ch == CW'(COLS - 1)) begin
              act_o <= 1'b0;
            end else begin
              ch     <= ch + 1'b1;
              addr_o <= addr_o + 1'b1;
            end
          end else begin
            px_o <= px_o + 1'b1;
          end
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cas_flash.sv
module cas_flash
  import cas_pkg::*;
#(
  parameter int FRW = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vs_rise,
  input  logic [1:0] duty,
  input  logic       flash_i,
  output logic       show_o
);
  localparam int QTR = 2**(FRW - 2);

  logic [FRW-1:0] frame;
  logic [FRW-1:0] thr;

  always_comb begin
    case (duty_e'(duty))
      DUTY_QTR:  thr = FRW'(QTR);
      DUTY_3QTR: thr = FRW'(3 * QTR);
      default:   thr = FRW'(2 * QTR);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame  <= '0;
      show_o <= 1'b1;
    end else begin
      if (vs_rise) frame <= frame + 1'b1;
      show_o <= !(flash_i && (frame >= thr));
    end
  end
endmodule

// File: rtl/char_addr_seq.sv
module char_addr_seq
  import cas_pkg::*;
#(
  parameter int ROWS   = ROWS_D,
  parameter int COLS   = COLS_D,
  parameter int CELL_W = CELL_W_D,
  parameter int CELL_H = CELL_H_D,
  parameter int AW     = AW_D,
  parameter int POSW   = POSW_D,
  parameter int SCW    = SCW_D,
  parameter int FRW    = FRW_D,
  parameter int H_UNIT = H_UNIT_D,
  parameter int V_UNIT = V_UNIT_D
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        hsync_i,
  input  logic                        vsync_i,
  input  logic [POSW-1:0]             h_start_i,
  input  logic [POSW-1:0]             v_start_i,
  input  logic [ROWS*AW-1:0]          row_base_i,
  input  logic [ROWS*SCW-1:0]         row_wsel_i,
  input  logic [ROWS*SCW-1:0]         row_hsel_i,
  input  logic [1:0]                  duty_i,
  input  logic                        flash_bit_i,
  output logic [AW-1:0]               ram_addr_o,
  output logic                        char_act_o,
  output logic [$clog2(CELL_W)-1:0]   pix_x_o,
  output logic [$clog2(CELL_H)-1:0]   pix_y_o,
  output logic                        show_o
);
  localparam int RW = $clog2(ROWS);

  logic [1:0]    sync_lvl;
  logic [1:0]    sync_rise;
  logic          v_on;
  logic [RW-1:0] row;

  assign sync_lvl[SYNC_H] = hsync_i;
  assign sync_lvl[SYNC_V] = vsync_i;

  for (genvar s = 0; s < 2; s++) begin : g_sync
    cas_sync_edge u_edge (
      .clk    (clk),
      .rst    (rst),
      .lvl_i  (sync_lvl[s]),
      .rise_o (sync_rise[s])
    );
  end

  cas_vseq #(
    .ROWS(ROWS), .CELL_H(CELL_H), .POSW(POSW), .SCW(SCW), .V_UNIT(V_UNIT)
  ) u_vseq (
    .clk       (clk),
    .rst       (rst),
    .hs_rise   (sync_rise[SYNC_H]),
    .vs_rise   (sync_rise[SYNC_V]),
    .v_start   (v_start_i),
    .hsel_flat (row_hsel_i),
    .v_on_o    (v_on),
    .row_o     (row),
    .cy_o      (pix_y_o)
  );

  cas_hseq #(
    .ROWS(ROWS), .COLS(COLS), .CELL_W(CELL_W), .AW(AW),
    .POSW(POSW), .SCW(SCW), .H_UNIT(H_UNIT)
  ) u_hseq (
    .clk       (clk),
    .rst       (rst),
    .hs_rise   (sync_rise[SYNC_H]),
    .vs_rise   (sync_rise[SYNC_V]),
    .h_start   (h_start_i),
    .v_on      (v_on),
    .row       (row),
    .base_flat (row_base_i),
    .wsel_flat (row_wsel_i),
    .act_o     (char_act_o),
    .addr_o    (ram_addr_o),
    .px_o      (pix_x_o)
  );

  cas_flash #(.FRW(FRW)) u_flash (
    .clk     (clk),
    .rst     (rst),
    .vs_rise (sync_rise[SYNC_V]),
    .duty    (duty_i),
    .flash_i (flash_bit_i),
    .show_o  (show_o)
  );
endmodule

// File: rtl/char_addr_seq_chk.sv
module char_addr_seq_chk #(
  parameter int AW     = 9,
  parameter int CELL_W = 12
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      hsync_i,
  input logic                      vsync_i,
  input logic                      flash_bit_i,
  input logic                      char_act_o,
  input logic [AW-1:0]             ram_addr_o,
  input logic [$clog2(CELL_W)-1:0] pix_x_o,
  input logic                      show_o
);
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !char_act_o |=> (char_act_o || $stable(ram_addr_o)));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (char_act_o && $past(char_act_o) && !$stable(ram_addr_o))
      |-> (ram_addr_o == ($past(ram_addr_o) + {{(AW-1){1'b0}}, 1'b1})));

  // R4
  pix_range_chk: assert property (@(posedge clk) disable iff (rst)
    char_act_o |-> (int'(pix_x_o) < CELL_W));

  // R4
  pix_step_chk: assert property (@(posedge clk) disable iff (rst)
    (char_act_o && $past(char_act_o) && !$stable(pix_x_o))
      |-> ((int'(pix_x_o) == int'($past(pix_x_o)) + 1) ||
           (pix_x_o == '0 && int'($past(pix_x_o)) == CELL_W - 1)));

  // R7
  hs_kill_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_i) |=> !char_act_o);

  // R7
  vs_kill_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync_i) |=> !char_act_o);

  // R9
  show_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !flash_bit_i |=> show_o);
endmodule

bind char_addr_seq char_addr_seq_chk #(.AW(AW), .CELL_W(CELL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hsync_i     (hsync_i),
  .vsync_i     (vsync_i),
  .flash_bit_i (flash_bit_i),
  .char_act_o  (char_act_o),
  .ram_addr_o  (ram_addr_o),
  .pix_x_o     (pix_x_o),
  .show_o      (show_o)
);

// File: tb/sim_char_addr_seq.sv
`timescale 1ns/1ps
module sim_char_addr_seq;
  localparam int ROWS = 12;
  localparam int COLS = 24;
  localparam int CW   = 12;
  localparam int CH   = 18;
  localparam int AW   = 9;
  localparam int HU   = 2;
  localparam int VU   = 1;

  logic clk = 1'b0;
  logic rst;
  logic hsync, vsync;
  logic [5:0] hstart_v, vstart_v;
  logic [ROWS*AW-1:0] base_v;
  logic [ROWS*2-1:0] ws_v, hs_v;
  logic [1:0] duty_v;
  logic flash_bit;
  logic [AW-1:0] addr;
  logic act;
  logic [3:0] px;
  logic [4:0] py;
  logic show;

  int hst, vst, duty;
  int base [ROWS];
  int ws [ROWS];
  int hsl [ROWS];
  int L, frame_m, last_addr;
  bit vs_prev;
  int checks, fails;
  bit done;

  always #2 clk = ~clk;

  char_addr_seq u0 (
    .clk(clk), .rst(rst), .hsync_i(hsync), .vsync_i(vsync),
    .h_start_i(hstart_v), .v_start_i(vstart_v), .row_base_i(base_v),
    .row_wsel_i(ws_v), .row_hsel_i(hs_v), .duty_i(duty_v),
    .flash_bit_i(flash_bit), .ram_addr_o(addr), .char_act_o(act),
    .pix_x_o(px), .pix_y_o(py), .show_o(show)
  );

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int thr(input int d);
    if (d == 1) return 16;
    if (d == 3) return 48;
    return 32;
  endfunction

  function automatic void vinfo(input int ln, output bit in, output int row, output int y);
    int off;
    off = ln - vst * VU;
    in = 0; row = 0; y = 0;
    if (off < 0) return;
    for (int r = 0; r < ROWS; r++) begin
      if (off < CH * (hsl[r] + 1)) begin
        in = 1; row = r; y = off / (hsl[r] + 1);
        return;
      end
      off -= CH * (hsl[r] + 1);
    end
  endfunction

  task automatic apply_cfg();
    hstart_v = 6'(hst);
    vstart_v = 6'(vst);
    duty_v   = 2'(duty);
    for (int r = 0; r < ROWS; r++) begin
      base_v[r*AW +: AW] = AW'(base[r]);
      ws_v[r*2 +: 2]     = 2'(ws[r]);
      hs_v[r*2 +: 2]     = 2'(hsl[r]);
    end
  endtask

  // one clock: model the flash gate (R8, R9) and compare all outputs
  task automatic cyc(input bit ea, input int eaddr, input int epx, input int epy);
    bit fl, vs, es;
    int d;
    fl = flash_bit; vs = vsync; d = duty;
    @(posedge clk);
    es = !(fl && (frame_m >= thr(d)));
    if (vs && !vs_prev) frame_m = (frame_m + 1) % 64;
    vs_prev = vs;
    @(negedge clk);
    chk(show == es, "R9 flash gate", int'(show), int'(es));
    chk(act == ea, "R2 active window", int'(act), int'(ea));
    if (ea) begin
      chk(int'(addr) == eaddr, "R5 address", int'(addr), eaddr);
      chk(int'(px) == epx, "R4 pixel column", int'(px), epx);
      chk(int'(py) == epy, "R3 scan line", int'(py), epy);
      last_addr = eaddr;
    end else begin
      chk(int'(addr) == last_addr, "R6 address hold", int'(addr), last_addr);
    end
    flash_bit = 1'($urandom % 2);
  endtask

  task automatic vpulse(input int len);
    for (int k = 0; k < len; k++) begin
      vsync = 1'b1;
      cyc(1'b0, 0, 0, 0);
    end
    vsync = 1'b0;
    L = 0;
  endtask

  // one scan line: hsync high for hs_len cycles (R10), n samples, optional vsync at vs_at (R7)
  task automatic line(input int hs_len, input int n, input int vs_at);
    bit in, killed, ea;
    int row, y, s, w, t, j, ea_addr, ea_px;
    vinfo(L, in, row, y);
    s = hst * HU + 1;
    w = ws[row] + 1;
    t = COLS * CW * w;
    killed = 0;
    for (int k = 0; k < n; k++) begin
      hsync = (k < hs_len);
      vsync = (k == vs_at);
      if (k == vs_at) killed = 1;
      j = k - s;
      ea = in && !killed && (k >= s) && (j < t);
      ea_addr = 0; ea_px = 0;
      if (ea) begin
        ea_addr = (base[row] + j / (CW * w)) % (1 << AW);
        ea_px = (j / w) % CW;
      end
      cyc(ea, ea_addr, ea_px, y);
    end
    hsync = 1'b0;
    vsync = 1'b0;
    if (vs_at >= 0) L = 0; else L++;
  endtask

  task automatic run_frame(input int full_div);
    int nlines, prev_row, total, row, y, s, n;
    bit in;
    total = 0;
    for (int r = 0; r < ROWS; r++) total += CH * (hsl[r] + 1);
    nlines = vst * VU + total + 3;
    prev_row = -1;
    for (int i = 0; i < nlines; i++) begin
      vinfo(L, in, row, y);
      s = hst * HU + 1;
      if (in && (row != prev_row || ($urandom % full_div) == 0))
        n = s + COLS * CW * (ws[row] + 1) + 3;
      else if (in)
        n = s + 18 + ($urandom % 10);
      else
        n = s + 6;
      if (in) prev_row = row;
      line(1 + ($urandom % 3), n, -1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    checks = 0; fails = 0; done = 0;
    L = 0; frame_m = 0; last_addr = 0; vs_prev = 0;
    hsync = 0; vsync = 0; flash_bit = 0;
    hst = 0; vst = 0; duty = 2;
    for (int r = 0; r < ROWS; r++) begin base[r] = 0; ws[r] = 0; hsl[r] = 0; end
    apply_cfg();
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(act == 1'b0, "R1 reset active", int'(act), 0);
    chk(addr == '0, "R1 reset address", int'(addr), 0);
    chk(px == '0, "R1 reset column", int'(px), 0);
    chk(py == '0, "R1 reset line", int'(py), 0);
    chk(show == 1'b1, "R1 reset gate", int'(show), 1);
    rst = 1'b0;

    // frame A: random config, row 3 base near top of memory for the R5 wrap
    hst = $urandom % 16; vst = $urandom % 8; duty = $urandom % 4;
    for (int r = 0; r < ROWS; r++) begin
      base[r] = $urandom % (1 << AW); ws[r] = $urandom % 4; hsl[r] = $urandom % 4;
    end
    base[3] = (1 << AW) - 2;
    apply_cfg();
    vpulse(1 + ($urandom % 3));
    run_frame(64);

    // frame B: both start offsets at their maximum, one line per pixel
    hst = 63; vst = 63; duty = $urandom % 4;
    for (int r = 0; r < ROWS; r++) begin
      base[r] = $urandom % (1 << AW); ws[r] = $urandom % 4; hsl[r] = 0;
    end
    apply_cfg();
    vpulse(2);
    run_frame(100000);

    // frame C: zero offsets, vsync in mid-row restarts row order (R7)
    hst = 0; vst = 0;
    for (int r = 0; r < ROWS; r++) begin base[r] = 17 * r; ws[r] = 0; hsl[r] = 0; end
    apply_cfg();
    vpulse(1);
    line(1, 60, -1);
    line(2, 120, 50);
    line(1, 40, -1);
    line(3, 40, -1);
    line(1, 40, -1);

    // flash duty sweep over more than one 64-frame period per code (R8, R9)
    for (int d = 0; d < 4; d++) begin
      duty = d;
      apply_cfg();
      for (int f = 0; f < 66; f++) begin
        vpulse(1);
        cyc(1'b0, 0, 0, 0);
        cyc(1'b0, 0, 0, 0);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule